// File: doc/BRIEF.md
# MAC control register file

This block is the software-visible register set of an Ethernet MAC. A simple 32-bit bus (request, write enable, byte address, write data; read data returned one cycle after a read request) reaches the operating-mode, inter-packet-gap, frame-length, collision, management-mode, interrupt and descriptor-count registers. The same bus reaches the 48-bit station address, which is split over two words, and a window onto the buffer-descriptor RAM. Every register value is driven out as a plain port for the datapath, the DMA engines and the management logic.

The descriptor RAM has a second port for the DMA engines. That port writes in the same cycle and reads one cycle after the address is presented. The interrupt-source register collects set pulses from the engines. Software clears its bits by writing 1. The interrupt line is the OR of the source bits that are enabled in the mask. Writing the transmit descriptor count also moves the receive descriptor index to the same value.

Top module: `mac_ctrl_regs`

## Requirements
- R1: After reset the registers read as follows:
  - mode 0x0000A000 (offset 0x00)
  - interrupt source 0 (0x04)
  - interrupt mask 0 (0x08)
  - IPGT 0x00000012 (0x0C)
  - IPGR1 0x0000000C (0x10)
  - IPGR2 0x00000012 (0x14)
  - frame length 0x003C0600 (0x18)
  - collision config 0x000F003F (0x1C)
  - management mode 0x00000064 (0x24)
  - descriptor count 0x80 (0x20)
  - both address words 0 (0x40, 0x44)
- R2: The frame-length register drives min_len_o from bits 31:16 and max_len_o from bits 15:0. After reset these outputs are 60 and 1536.
- R3: A write to offset 0x20 keeps only bits 7:0. The same write loads those 8 bits into rx_bd_idx_o. Out of reset, rx_bd_idx_o equals the reset descriptor count, 0x80.
- R4: Address word 0 (0x40) holds station bytes 3,2,1,0 from bit 31 down to bit 0. station_addr_o carries byte k in bits 8k+7:8k.
- R5: Address word 1 (0x44) holds byte 5 in bits 15:8 and byte 4 in bits 7:0. A write keeps only those 16 bits, and bits 31:16 read as 0.
- R6: A bus access at byte address 0x400 + 4*n, for n below BD_WORDS, reads or writes descriptor word n. A word written from the bus is seen by the DMA read port, and a word written by the DMA port is seen on the bus.
- R7: When the bus and the DMA port write the same descriptor word in the same cycle, the DMA data is stored. Writes to different words in the same cycle both take effect.
- R8: Writing 1 to a bit of the interrupt-source register clears that bit. Writing 0 leaves the bit unchanged. Each irq_set_i bit sets the matching source bit.
- R9: A set pulse and a software clear on the same bit in the same cycle leave the bit set.
- R10: irq_o is high exactly when some bit is set in both the interrupt source and the interrupt mask.
- R11: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register and no descriptor word. This includes offsets past the end of the descriptor window.
- R12: bus_rdata_o is loaded only on the clock edge that takes a read request, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| dma_we_i | input | 1 | DMA descriptor write enable |
| dma_addr_i | input | log2(BD_WORDS) | DMA descriptor word index |
| dma_wdata_i | input | 32 | DMA descriptor write data |
| dma_rdata_o | output | 32 | DMA descriptor read data, one cycle after the address |
| irq_set_i | input | IRQ_W | Interrupt set pulses from the engines |
| irq_o | output | 1 | Masked interrupt request |
| mode_o | output | 32 | Mode register |
| ipgt_o | output | 32 | Back-to-back gap register |
| ipgr1_o | output | 32 | Non-back-to-back gap 1 |
| ipgr2_o | output | 32 | Non-back-to-back gap 2 |
| min_len_o | output | 16 | Minimum frame length |
| max_len_o | output | 16 | Maximum frame length |
| coll_cfg_o | output | 32 | Collision configuration |
| mii_mode_o | output | 32 | Management-interface mode |
| tx_bd_num_o | output | 8 | Transmit descriptor count |
| rx_bd_idx_o | output | 8 | Receive descriptor index |
| station_addr_o | output | 48 | Station address, byte k at bits 8k+7:8k |

## Verification
The hardest cases to reach are the same-cycle conflicts. One is a DMA write and a bus write to the same descriptor word. The other is an engine set pulse and a software write-1-to-clear on the same interrupt bit. The bench reaches both by driving the two inputs together on a single falling edge, so that one rising edge takes both. It then reads the result back through the bus. Aliasing of the descriptor window is exposed by writing just past the window's end and then reading descriptor word 0.

// File: rtl/mac_regs_pkg.sv
`timescale 1ns/1ps
package mac_regs_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned TXN_W = 8;

  localparam logic [7:0] OFF_MODE = 8'h00;
  localparam logic [7:0] OFF_ISRC = 8'h04;
  localparam logic [7:0] OFF_IMSK = 8'h08;
  localparam logic [7:0] OFF_IPGT = 8'h0C;
  localparam logic [7:0] OFF_IPR1 = 8'h10;
  localparam logic [7:0] OFF_IPR2 = 8'h14;
  localparam logic [7:0] OFF_PLEN = 8'h18;
  localparam logic [7:0] OFF_COLL = 8'h1C;
  localparam logic [7:0] OFF_TXN  = 8'h20;
  localparam logic [7:0] OFF_MII  = 8'h24;
  localparam logic [7:0] OFF_ADR0 = 8'h40;
  localparam logic [7:0] OFF_ADR1 = 8'h44;

  localparam logic [DW-1:0]    RST_MODE = 32'h0000_A000;
  localparam logic [DW-1:0]    RST_IPGT = 32'h0000_0012;
  localparam logic [DW-1:0]    RST_IPR1 = 32'h0000_000C;
  localparam logic [DW-1:0]    RST_IPR2 = 32'h0000_0012;
  localparam logic [DW-1:0]    RST_PLEN = 32'h003C_0600;
  localparam logic [DW-1:0]    RST_COLL = 32'h000F_003F;
  localparam logic [DW-1:0]    RST_MII  = 32'h0000_0064;
  localparam logic [TXN_W-1:0] RST_TXN  = 8'h80;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_ISRC, SEL_IMSK, SEL_IPGT, SEL_IPR1, SEL_IPR2,
    SEL_PLEN, SEL_COLL, SEL_TXN, SEL_MII, SEL_ADR0, SEL_ADR1, SEL_BD
  } reg_sel_e;
endpackage

// File: rtl/mac_reg_decode.sv
`timescale 1ns/1ps
module mac_reg_decode
  import mac_regs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned BD_BASE  = 'h400,
  parameter int unsigned BD_WORDS = 128,
  localparam int unsigned BD_AW   = $clog2(BD_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [BD_AW-1:0]  bd_idx_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BD_BASE);
  localparam logic [ADDR_W-3:0] LIM_W  = (ADDR_W-2)'(BD_WORDS);

  logic [ADDR_W-1:0] off;
  logic              in_win;

  assign off      = addr_i - BASE_A;
  assign in_win   = (addr_i >= BASE_A) && (off[ADDR_W-1:2] < LIM_W);
  assign bd_idx_o = off[BD_AW+1:2];

  always_comb begin
    sel_o = SEL_NONE;
    if (in_win) begin
      sel_o = SEL_BD;
    end else if (addr_i[ADDR_W-1:8] == '0) begin
      unique case (addr_i[7:0])
        OFF_MODE: sel_o = SEL_MODE;
        OFF_ISRC: sel_o = SEL_ISRC;
        OFF_IMSK: sel_o = SEL_IMSK;
        OFF_IPGT: sel_o = SEL_IPGT;
        OFF_IPR1: sel_o = SEL_IPR1;
        OFF_IPR2: sel_o = SEL_IPR2;
        OFF_PLEN: sel_o = SEL_PLEN;
        OFF_COLL: sel_o = SEL_COLL;
        OFF_TXN:  sel_o = SEL_TXN;
        OFF_MII:  sel_o = SEL_MII;
        OFF_ADR0: sel_o = SEL_ADR0;
        OFF_ADR1: sel_o = SEL_ADR1;
        default:  sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mac_irq_src.sv
`timescale 1ns/1ps
module mac_irq_src #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] src_o,
  output logic         irq_o
);
  logic [W-1:0] src_q;

  // set dominates a simultaneous write-1 clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= (src_q & ~clr_i) | set_i;
  end

  assign src_o = src_q;
  assign irq_o = |(src_q & mask_i);

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((src_q & $past(set_i)) == $past(set_i)));

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((src_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/mac_desc_ram.sv
`timescale 1ns/1ps
module mac_desc_ram #(
  parameter int unsigned WORDS = 128,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  input  logic          d_we_i,
  input  logic [AW-1:0] d_addr_i,
  input  logic [DW-1:0] d_wdata_i,
  output logic [DW-1:0] d_rdata_o
);
  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] d_rdata_q;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[i] <= '0;
      else if (d_we_i && d_addr_i == AW'(i))       mem_q[i] <= d_wdata_i;
      else if (b_we_i && b_addr_i == AW'(i))       mem_q[i] <= b_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_rdata_q <= '0;
    else         d_rdata_q <= mem_q[d_addr_i];
  end

  assign b_rdata_o = mem_q[b_addr_i];
  assign d_rdata_o = d_rdata_q;

  p_dma_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_we_i && b_we_i && d_addr_i == b_addr_i) |=> (mem_q[$past(d_addr_i)] == $past(d_wdata_i)));
endmodule

// File: rtl/mac_ctrl_regs.sv
`timescale 1ns/1ps
module mac_ctrl_regs
  import mac_regs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned BD_BASE  = 'h400,
  parameter int unsigned BD_WORDS = 128,
  parameter int unsigned IRQ_W    = 7,
  localparam int unsigned BD_AW   = $clog2(BD_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              dma_we_i,
  input  logic [BD_AW-1:0]  dma_addr_i,
  input  logic [31:0]       dma_wdata_i,
  output logic [31:0]       dma_rdata_o,
  input  logic [IRQ_W-1:0]  irq_set_i,
  output logic              irq_o,
  output logic [31:0]       mode_o,
  output logic [31:0]       ipgt_o,
  output logic [31:0]       ipgr1_o,
  output logic [31:0]       ipgr2_o,
  output logic [15:0]       min_len_o,
  output logic [15:0]       max_len_o,
  output logic [31:0]       coll_cfg_o,
  output logic [31:0]       mii_mode_o,
  output logic [7:0]        tx_bd_num_o,
  output logic [7:0]        rx_bd_idx_o,
  output logic [47:0]       station_addr_o
);
  reg_sel_e          sel;
  logic [BD_AW-1:0]  bd_idx;
  logic              wr, rd;

  logic [DW-1:0]     mode_q, ipgt_q, ipr1_q, ipr2_q, plen_q, coll_q, mii_q;
  logic [TXN_W-1:0]  txn_q, rx_idx_q;
  logic [47:0]       sta_q;
  logic [IRQ_W-1:0]  imsk_q, isrc, irq_clr;
  logic [DW-1:0]     bd_rdata, rd_mux, rdata_q;

  assign wr = bus_req_i &  bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;

  mac_reg_decode #(.ADDR_W(ADDR_W), .BD_BASE(BD_BASE), .BD_WORDS(BD_WORDS)) u_dec (
    .addr_i   (bus_addr_i),
    .sel_o    (sel),
    .bd_idx_o (bd_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= RST_MODE;
      ipgt_q   <= RST_IPGT;
      ipr1_q   <= RST_IPR1;
      ipr2_q   <= RST_IPR2;
      plen_q   <= RST_PLEN;
      coll_q   <= RST_COLL;
      mii_q    <= RST_MII;
      txn_q    <= RST_TXN;
      rx_idx_q <= RST_TXN;
      sta_q    <= '0;
      imsk_q   <= '0;
    end else if (wr) begin
      unique case (sel)
        SEL_MODE: mode_q <= bus_wdata_i;
        SEL_IPGT: ipgt_q <= bus_wdata_i;
        SEL_IPR1: ipr1_q <= bus_wdata_i;
        SEL_IPR2: ipr2_q <= bus_wdata_i;
        SEL_PLEN: plen_q <= bus_wdata_i;
        SEL_COLL: coll_q <= bus_wdata_i;
        SEL_MII:  mii_q  <= bus_wdata_i;
        SEL_IMSK: imsk_q <= bus_wdata_i[IRQ_W-1:0];
        SEL_TXN: begin
          txn_q    <= bus_wdata_i[TXN_W-1:0];
          rx_idx_q <= bus_wdata_i[TXN_W-1:0];
        end
        SEL_ADR0: sta_q[31:0]  <= bus_wdata_i;
        SEL_ADR1: sta_q[47:32] <= bus_wdata_i[15:0];
        default: ;
      endcase
    end
  end

  assign irq_clr = (wr && sel == SEL_ISRC) ? bus_wdata_i[IRQ_W-1:0] : '0;

  mac_irq_src #(.W(IRQ_W)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set_i),
    .clr_i  (irq_clr),
    .mask_i (imsk_q),
    .src_o  (isrc),
    .irq_o  (irq_o)
  );

  mac_desc_ram #(.WORDS(BD_WORDS), .DW(DW)) u_bd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .b_we_i    (wr && sel == SEL_BD),
    .b_addr_i  (bd_idx),
    .b_wdata_i (bus_wdata_i),
    .b_rdata_o (bd_rdata),
    .d_we_i    (dma_we_i),
    .d_addr_i  (dma_addr_i),
    .d_wdata_i (dma_wdata_i),
    .d_rdata_o (dma_rdata_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_MODE: rd_mux = mode_q;
      SEL_ISRC: rd_mux = {{(DW-IRQ_W){1'b0}}, isrc};
      SEL_IMSK: rd_mux = {{(DW-IRQ_W){1'b0}}, imsk_q};
      SEL_IPGT: rd_mux = ipgt_q;
      SEL_IPR1: rd_mux = ipr1_q;
      SEL_IPR2: rd_mux = ipr2_q;
      SEL_PLEN: rd_mux = plen_q;
      SEL_COLL: rd_mux = coll_q;
      SEL_MII:  rd_mux = mii_q;
      SEL_TXN:  rd_mux = {{(DW-TXN_W){1'b0}}, txn_q};
      SEL_ADR0: rd_mux = sta_q[31:0];
      SEL_ADR1: rd_mux = {16'h0, sta_q[47:32]};
      SEL_BD:   rd_mux = bd_rdata;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign bus_rdata_o    = rdata_q;
  assign mode_o         = mode_q;
  assign ipgt_o         = ipgt_q;
  assign ipgr1_o        = ipr1_q;
  assign ipgr2_o        = ipr2_q;
  assign min_len_o      = plen_q[31:16];
  assign max_len_o      = plen_q[15:0];
  assign coll_cfg_o     = coll_q;
  assign mii_mode_o     = mii_q;
  assign tx_bd_num_o    = txn_q;
  assign rx_bd_idx_o    = rx_idx_q;
  assign station_addr_o = sta_q;

  p_rx_idx_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_TXN) |=> (rx_bd_idx_o == $past(bus_wdata_i[7:0])));

  p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_NONE) |=> (bus_rdata_o == '0));

  p_rdata_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(bus_rdata_o));

  p_adr1_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_ADR1) |=> (bus_rdata_o[31:16] == 16'h0));
endmodule

// File: tb/mac_ctrl_regs_tb.sv
`timescale 1ns/1ps
module mac_ctrl_regs_tb;
  localparam int ADDR_W = 11;
  localparam int IRQ_W  = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic dma_we = 0;
  logic [6:0] dma_addr = '0;
  logic [31:0] dma_wdata = '0, dma_rdata;
  logic [IRQ_W-1:0] irq_set = '0;
  logic irq;
  logic [31:0] mode, ipgt, ipgr1, ipgr2, coll, mii;
  logic [15:0] min_len, max_len;
  logic [7:0] txn, rx_idx;
  logic [47:0] sta;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mac_ctrl_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .dma_we_i(dma_we), .dma_addr_i(dma_addr), .dma_wdata_i(dma_wdata),
    .dma_rdata_o(dma_rdata), .irq_set_i(irq_set), .irq_o(irq),
    .mode_o(mode), .ipgt_o(ipgt), .ipgr1_o(ipgr1), .ipgr2_o(ipgr2),
    .min_len_o(min_len), .max_len_o(max_len), .coll_cfg_o(coll),
    .mii_mode_o(mii), .tx_bd_num_o(txn), .rx_bd_idx_o(rx_idx),
    .station_addr_o(sta)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic dma_rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    dma_addr = a;
    @(negedge clk);
    d = dma_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(11'h00, v); chk("R1 mode", v, 32'h0000A000);
    rd(11'h04, v); chk("R1 isrc", v, 0);
    rd(11'h08, v); chk("R1 imsk", v, 0);
    rd(11'h0C, v); chk("R1 ipgt", v, 32'h12);
    rd(11'h10, v); chk("R1 ipgr1", v, 32'h0C);
    rd(11'h14, v); chk("R1 ipgr2", v, 32'h12);
    rd(11'h18, v); chk("R1 plen", v, 32'h003C0600);
    rd(11'h1C, v); chk("R1 coll", v, 32'h000F003F);
    rd(11'h24, v); chk("R1 mii", v, 32'h64);
    rd(11'h20, v); chk("R1 txn", v, 32'h80);
    rd(11'h40, v); chk("R1 adr0", v, 0);
    rd(11'h44, v); chk("R1 adr1", v, 0);
    chk("R2 min_len", min_len, 60);
    chk("R2 max_len", max_len, 1536);
    chk("R3 rx_idx reset", rx_idx, 8'h80);
    chk("R10 irq reset", irq, 0);
  endtask

  task automatic t_plen();
    wr(11'h18, 32'h0040_05EE);
    chk("R2 min_len new", min_len, 16'h0040);
    chk("R2 max_len new", max_len, 16'h05EE);
  endtask

  task automatic t_txn();
    logic [31:0] v;
    wr(11'h20, 32'hDEAD_BE37);
    rd(11'h20, v);
    chk("R3 txn low byte", v, 32'h37);
    chk("R3 rx_idx load", rx_idx, 8'h37);
    chk("R3 tx_bd_num_o", txn, 8'h37);
  endtask

  task automatic t_station();
    logic [31:0] v;
    wr(11'h40, 32'h4433_2211);
    wr(11'h44, 32'hFFFF_6655);
    rd(11'h44, v);
    chk("R5 adr1 16 bits", v, 32'h0000_6655);
    rd(11'h40, v);
    chk("R4 adr0", v, 32'h4433_2211);
    chk("R4 station_addr_o", sta, 48'h6655_4433_2211);
  endtask

  task automatic t_bd();
    logic [31:0] v;
    wr(11'h40C, 32'hCAFE_0003);
    dma_rd(7'd3, v); chk("R6 bus->dma word3", v, 32'hCAFE_0003);
    @(negedge clk); dma_we = 1; dma_addr = 7'd127; dma_wdata = 32'h1234_007F;
    @(negedge clk); dma_we = 0;
    rd(11'h5FC, v); chk("R6 dma->bus word127", v, 32'h1234_007F);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 11'h414; bus_wdata = 32'hAAAA_AAAA;
    dma_we = 1; dma_addr = 7'd5; dma_wdata = 32'h5555_5555;
    @(negedge clk);
    bus_req = 0; bus_we = 0; dma_we = 0;
    rd(11'h414, v); chk("R7 dma wins", v, 32'h5555_5555);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 11'h418; bus_wdata = 32'h0000_0B06;
    dma_we = 1; dma_addr = 7'd7; dma_wdata = 32'h0000_0D07;
    @(negedge clk);
    bus_req = 0; bus_we = 0; dma_we = 0;
    rd(11'h418, v); chk("R7 bus word6", v, 32'h0B06);
    rd(11'h41C, v); chk("R7 dma word7", v, 32'h0D07);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    @(negedge clk); irq_set = 7'b000_0110;
    @(negedge clk); irq_set = '0;
    rd(11'h04, v); chk("R8 set", v, 32'h06);
    chk("R10 irq masked off", irq, 0);
    wr(11'h08, 32'h04);
    chk("R10 irq enabled", irq, 1);
    wr(11'h04, 32'h02);
    rd(11'h04, v); chk("R8 w1c bit1", v, 32'h04);
    @(negedge clk);
    irq_set = 7'b000_0100;
    bus_req = 1; bus_we = 1; bus_addr = 11'h04; bus_wdata = 32'h04;
    @(negedge clk);
    irq_set = '0; bus_req = 0; bus_we = 0;
    rd(11'h04, v); chk("R9 set beats clear", v, 32'h04);
    wr(11'h04, 32'h7F);
    rd(11'h04, v); chk("R8 clear all", v, 0);
    chk("R10 irq low after clear", irq, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v, m;
    rd(11'h00, m);
    wr(11'h30, 32'hFFFF_FFFF);
    rd(11'h30, v); chk("R11 unmapped read", v, 0);
    rd(11'h00, v); chk("R11 mode untouched", v, m);
    wr(11'h400, 32'h0000_00B0);
    wr(11'h600, 32'hBAD0_BAD0);
    rd(11'h600, v); chk("R11 past window read", v, 0);
    rd(11'h400, v); chk("R11 word0 untouched", v, 32'hB0);
    wr(11'h02, 32'h1);
    rd(11'h00, v); chk("R11 unaligned ignored", v, m);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    rd(11'h1C, v);
    wr(11'h0C, 32'h55);
    @(negedge clk);
    chk("R12 rdata held", bus_rdata, v);
    chk("R1 ipgt_o write", ipgt, 32'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_plen();
    t_txn();
    t_station();
    t_bd();
    t_collide();
    t_irq();
    t_unmapped();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule